// File: doc/BRIEF.md
# Text Window Start Sequencer

This block times the left edge of the text window on each scan line of a character-based video controller. It compares the horizontal position count with a programmable origin X value. The compare only counts while a line qualifier says that the current scan line lies inside the window. A hit starts a fixed registered chain of strobes. Each strobe sits at its own cycle offset from the hit.

The chain runs in this order:

- an internal in-window latch
- the bus-available indication
- the active-low in-window enable for the cell and matrix counters
- the address output enable
- a one-cycle cell-index fetch slot
- a one-cycle character-data fetch slot
- the border/pixel select, which moves the output from border colour to shift-register pixels

The first text pixel therefore appears six cycles after the hit, when the position count has moved six steps past the origin. The levels hold until the end-of-line strobe, which returns the whole chain to idle. A second small path keeps a registered active-low matrix-line flag and pulses the cell-depth counter enable at the end of each line that was inside the window.

Top module: `text_win_seq`

## Requirements
- R1: After reset, every output is idle: bus_avail_o=1, in_window_no=1, addr_oe_o=0, fetch_idx_o=0, fetch_chr_o=0, pixel_sel_o=0 (0 selects border), matrix_line_no=1, depth_en_o=0.
- R2: A hit is a cycle m where line_active_i=1 and hpos_i==origin_x_i. Only the first hit of a line starts the chain; later equal positions in the same line have no effect.
- R3: bus_avail_o goes low in cycle m+2 and stays low until the line is cleared.
- R4: in_window_no goes low in cycle m+3, one cycle after bus_avail_o falls, and stays low until cleared.
- R5: addr_oe_o goes high in cycle m+4, two cycles after bus_avail_o falls, and stays high until cleared.
- R6: fetch_idx_o is high for exactly one cycle, m+5.
- R7: fetch_chr_o is high for exactly one cycle, m+6.
- R8: pixel_sel_o goes high in cycle m+6 and stays high until cleared. With hpos_i advancing by one per cycle, hpos_i equals origin_x_i+6 in that cycle.
- R9: A cycle with line_end_i=1 returns every chain output to idle from the next cycle on. A hit that falls in that same cycle is dropped.
- R10: matrix_line_no in cycle n is the inverse of line_active_i in cycle n-1. depth_en_o is high in cycle n only when line_end_i was high in cycle n-1 and matrix_line_no was low in cycle n-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hpos_i | input | HPOS_W | Horizontal position count |
| origin_x_i | input | HPOS_W | Programmed screen origin X |
| line_active_i | input | 1 | Current scan line lies inside the text window |
| line_end_i | input | 1 | Last cycle of the scan line |
| bus_avail_o | output | 1 | Bus available, low once the window fetches are close |
| in_window_no | output | 1 | Active-low in-window, enables cell and matrix counters |
| addr_oe_o | output | 1 | Address output enable |
| fetch_idx_o | output | 1 | Cell-index fetch slot |
| fetch_chr_o | output | 1 | Character-data fetch slot |
| pixel_sel_o | output | 1 | 1 selects shift-register pixels, 0 selects border |
| matrix_line_no | output | 1 | Registered active-low matrix-line flag |
| depth_en_o | output | 1 | Cell-depth counter enable pulse |

## Verification
The assertions check the relative order of the strobes on every cycle:

- in-window falls only one cycle after bus-available has fallen
- the address enable rises only after in-window is low
- the index slot is followed by the character slot
- the character slot implies pixel select
- an end-of-line strobe leaves the chain idle
- a depth pulse is preceded by an end-of-line strobe

The absolute offsets from the hit need the bench's scenarios:

- the exact cycle of each strobe against the origin
- ignoring repeated matches and unqualified lines
- dropping a hit that lands on the end-of-line cycle
- recovery after a reset in mid-sequence

// File: rtl/tws_pkg.sv
package tws_pkg;
  // chain taps, counted in cycles after the hit minus one
  localparam int unsigned TAP_WIN  = 0;
  localparam int unsigned TAP_BUS  = 1;
  localparam int unsigned TAP_MTX  = 2;
  localparam int unsigned TAP_AOE  = 3;
  localparam int unsigned TAP_IDX  = 4;
  localparam int unsigned TAP_CHR  = 5;
  localparam int unsigned TAP_TAIL = 6;
  localparam int unsigned CHAIN_LEN = TAP_TAIL + 1;
endpackage

// File: rtl/tws_match.sv
module tws_match #(
  parameter int unsigned HPOS_W = 9
) (
  input  logic [HPOS_W-1:0] hpos_i,
  input  logic [HPOS_W-1:0] origin_x_i,
  input  logic              line_active_i,
  input  logic              armed_i,
  output logic              hit_o
);
  always_comb hit_o = line_active_i && armed_i && (hpos_i == origin_x_i);
endmodule

// File: rtl/tws_chain.sv
module tws_chain #(
  parameter int unsigned LEN = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           hit_i,
  output logic [LEN-1:0] st_o
);
  for (genvar i = 0; i < LEN; i++) begin : g_stage
    logic feed;
    if (i == 0) begin : g_head
      always_comb feed = hit_i;
    end else begin : g_body
      always_comb feed = st_o[i-1];
    end
    // sticky stage: set by its feed, held until end of line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_o[i] <= 1'b0;
      else if (clr_i) st_o[i] <= 1'b0;
      else if (feed)  st_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/tws_line.sv
module tws_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_active_i,
  input  logic line_end_i,
  output logic matrix_line_no,
  output logic depth_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      matrix_line_no <= 1'b1;
      depth_en_o     <= 1'b0;
    end else begin
      matrix_line_no <= ~line_active_i;
      depth_en_o     <= line_end_i & ~matrix_line_no;
    end
  end

  a_r10_depth_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_en_o |-> $past(line_end_i));
endmodule

// File: rtl/text_win_seq.sv
module text_win_seq #(
  parameter int unsigned HPOS_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HPOS_W-1:0] hpos_i,
  input  logic [HPOS_W-1:0] origin_x_i,
  input  logic              line_active_i,
  input  logic              line_end_i,
  output logic              bus_avail_o,
  output logic              in_window_no,
  output logic              addr_oe_o,
  output logic              fetch_idx_o,
  output logic              fetch_chr_o,
  output logic              pixel_sel_o,
  output logic              matrix_line_no,
  output logic              depth_en_o
);
  import tws_pkg::*;

  logic                 hit;
  logic [CHAIN_LEN-1:0] st;

  tws_match #(.HPOS_W(HPOS_W)) match_i (
    .hpos_i        (hpos_i),
    .origin_x_i    (origin_x_i),
    .line_active_i (line_active_i),
    .armed_i       (~st[TAP_WIN]),
    .hit_o         (hit)
  );

  tws_chain #(.LEN(CHAIN_LEN)) chain_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (line_end_i),
    .hit_i  (hit),
    .st_o   (st)
  );

  tws_line line_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .line_active_i  (line_active_i),
    .line_end_i     (line_end_i),
    .matrix_line_no (matrix_line_no),
    .depth_en_o     (depth_en_o)
  );

  always_comb begin
    bus_avail_o  = ~st[TAP_BUS];
    in_window_no = ~st[TAP_MTX];
    addr_oe_o    = st[TAP_AOE];
    fetch_idx_o  = st[TAP_IDX] & ~st[TAP_CHR];
    fetch_chr_o  = st[TAP_CHR] & ~st[TAP_TAIL];
    pixel_sel_o  = st[TAP_CHR];
  end

  a_r4_window_after_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_window_no) |-> $past(!bus_avail_o) && $past(in_window_no));
  a_r5_aoe_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_oe_o) |-> $past(!in_window_no));
  a_r6_idx_then_chr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_idx_o && !line_end_i) |=> fetch_chr_o);
  a_r7_chr_shows_pixels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_chr_o |-> pixel_sel_o);
  a_r7_one_fetch_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fetch_idx_o, fetch_chr_o}));
  a_r9_line_end_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_i |=> (bus_avail_o && in_window_no && !addr_oe_o && !pixel_sel_o));
endmodule

// File: tb/text_win_seq_tb_top.sv
`timescale 1ns/1ps
module text_win_seq_tb_top;
  localparam int unsigned HPOS_W = 9;
  localparam int LINE_LEN = 40;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [HPOS_W-1:0] hpos_i = '0;
  logic [HPOS_W-1:0] origin_x_i = '0;
  logic              line_active_i = 1'b0;
  logic              line_end_i = 1'b0;
  logic bus_avail_o, in_window_no, addr_oe_o, fetch_idx_o, fetch_chr_o;
  logic pixel_sel_o, matrix_line_no, depth_en_o;

  int n_chk = 0;
  int n_bad = 0;
  int g = 0;
  int match_g = -1;
  bit prev_end = 0, act_1 = 0, act_2 = 0, done = 0;

  always #2.5 clk_i = ~clk_i;

  text_win_seq #(.HPOS_W(HPOS_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hpos_i(hpos_i), .origin_x_i(origin_x_i),
    .line_active_i(line_active_i), .line_end_i(line_end_i),
    .bus_avail_o(bus_avail_o), .in_window_no(in_window_no), .addr_oe_o(addr_oe_o),
    .fetch_idx_o(fetch_idx_o), .fetch_chr_o(fetch_chr_o), .pixel_sel_o(pixel_sel_o),
    .matrix_line_no(matrix_line_no), .depth_en_o(depth_en_o)
  );

  task automatic chk(string req, string nm, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b cycle=%0d", req, nm, act, exp, g);
    end
  endtask

  // compare all outputs against the model, before this cycle's drive
  task automatic check_all();
    int d;
    d = (match_g >= 0) ? g - match_g : -1;
    chk("R3", "bus_avail_o",  bus_avail_o,  !(d >= 2));
    chk("R4", "in_window_no", in_window_no, !(d >= 3));
    chk("R5", "addr_oe_o",    addr_oe_o,    d >= 4);
    chk("R6", "fetch_idx_o",  fetch_idx_o,  d == 5);
    chk("R7", "fetch_chr_o",  fetch_chr_o,  d == 6);
    chk("R8", "pixel_sel_o",  pixel_sel_o,  d >= 6);
    chk("R10", "matrix_line_no", matrix_line_no, !act_1);
    chk("R10", "depth_en_o",  depth_en_o,   prev_end && act_2);
  endtask

  task automatic cyc(int hp, int org, bit act, bit lend);
    @(negedge clk_i);
    check_all();
    hpos_i = HPOS_W'(hp); origin_x_i = HPOS_W'(org);
    line_active_i = act; line_end_i = lend;
    // R2: first qualified equality; R9: end-of-line clears and drops a hit
    if (lend) match_g = -1;
    else if (match_g < 0 && act && hp == org) match_g = g;
    act_2 = act_1 && !prev_end ? act_1 : act_1;
    act_2 = act_1; act_1 = act; prev_end = lend;
    g++;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    line_active_i = 0; line_end_i = 0; hpos_i = '0;
    match_g = -1; prev_end = 0; act_1 = 0; act_2 = 0;
    @(negedge clk_i);
    // R1: idle values while in reset
    chk("R1", "bus_avail_o",  bus_avail_o, 1'b1);
    chk("R1", "in_window_no", in_window_no, 1'b1);
    chk("R1", "addr_oe_o",    addr_oe_o, 1'b0);
    chk("R1", "fetch_idx_o",  fetch_idx_o, 1'b0);
    chk("R1", "fetch_chr_o",  fetch_chr_o, 1'b0);
    chk("R1", "pixel_sel_o",  pixel_sel_o, 1'b0);
    chk("R1", "matrix_line_no", matrix_line_no, 1'b1);
    chk("R1", "depth_en_o",   depth_en_o, 1'b0);
    rst_ni = 1'b1;
  endtask

  // mode 0 ramp, 1 hold at origin for 5 cycles, 2 qualifier on odd cycles only
  task automatic line(int org, bit act, int mode);
    for (int i = 0; i < LINE_LEN; i++) begin
      int hp;
      bit a;
      hp = (mode == 1 && i < 5) ? org : i;
      a  = act && (mode != 2 || i[0]);
      cyc(hp, org, a, i == LINE_LEN - 1);
    end
  endtask

  initial begin
    do_reset();
    // R2 R3 R4 R5 R6 R7 R8 R9: sweep origin across and past the line
    for (int o = 0; o <= LINE_LEN + 1; o++) line(o, 1'b1, 0);
    // R2: unqualified lines never start
    for (int o = 0; o < 8; o++) line(o * 3, 1'b0, 0);
    // R2: repeated equality in one line starts once
    line(0, 1'b1, 1);
    line(7, 1'b1, 1);
    // R2: per-cycle qualifier
    for (int o = 2; o < 12; o++) line(o, 1'b1, 2);
    // R10: alternating active and inactive lines
    for (int k = 0; k < 6; k++) line(5, k[0], 0);
    // R1: reset in mid-sequence
    for (int i = 0; i < 9; i++) cyc(i, 4, 1'b1, 1'b0);
    do_reset();
    line(10, 1'b1, 0);
    cyc(0, 0, 1'b0, 1'b0);
    cyc(0, 0, 1'b0, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule